// File: doc/BRIEF.md
# Byte-wide EEPROM access sequencer

This block lets a host move single bytes to and from an external byte-wide EEPROM through a small register file. The host loads an EEPROM address and, for a store, a data byte. It then sets a read or a write request bit. The block drives a request/acknowledge byte port toward the EEPROM. When the access completes it clears the request bit, so the host polls that bit to learn when the result is ready.

The block also copies EEPROM contents into a 24-bit internal memory space without host help (burst mode). A burst first fetches a four-byte header: a 16-bit target offset, low byte first, then a 16-bit byte count, low byte first. It then reads that many bytes and writes each one to the memory port. The upper nine bits of each target address come from a base register. The lower fifteen bits come from the header offset, which increases by one per byte. The first EEPROM address of a burst depends on the history since reset: address 0 if nothing has been accessed yet, otherwise the address just after the last access.

The controller is a five-state machine:
- ST_IDLE goes to ST_RD when a read is requested. It goes to ST_WR when only a write is requested, and to ST_HDR when a burst is started.
- ST_RD and ST_WR return to ST_IDLE on the EEPROM done strobe.
- ST_HDR stays in place for the first three header bytes. On the fourth it moves to ST_COPY, or back to ST_IDLE when the count is zero.
- ST_COPY returns to ST_IDLE on the done strobe of the last data byte.

Top module: `nvb_seq`

## Requirements
- R1: Writing the control register (index 0) with bit 1 set starts a read of the EEPROM byte at the address register (index 1). The byte lands in bits [7:0] of the data register (index 2). Control bit 1 reads 1 until completion and 0 once the data is valid.
- R2: Writing the control register with bit 0 set (bit 1 clear) stores data register bits [7:0] at the address register location, with ee_we high. Control bit 0 reads 1 until the store completes.
- R3: If bits 1 and 0 are written as 1 together, only the read is performed. No cycle with ee_we high occurs, and the EEPROM byte is left unchanged.
- R4: Control bit 2 reads 1 while any operation runs. Register writes of any kind made during that time have no effect.
- R5: Writing bit 0 of the burst register (index 3) starts a burst. That bit reads 1 until the burst ends and then 0.
- R6: A burst reads consecutive EEPROM addresses. It starts at address 0 if no access of any kind has happened since reset, and otherwise at the address after the last one accessed.
- R7: The first four burst bytes are offset low, offset high, count low and count high. A count of 0 ends the burst with no memory writes.
- R8: Memory target addresses are {base register (index 4) bits [8:0], offset[14:0]}. Offset bit 15 is ignored, and the 15-bit offset advances by one per byte and wraps.
- R9: Each burst data byte appears on mem_wdata with a one-cycle mem_we pulse, in the cycle after its EEPROM done strobe.
- R10: After reset all registers read 0 and ee_req and mem_we are low. While ee_req is high and ee_done is low, ee_req, ee_addr and ee_we hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data of the indexed register |
| ee_req | output | 1 | EEPROM access request, held until done |
| ee_we | output | 1 | EEPROM access is a store |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | EEPROM store data |
| ee_rdata | input | 8 | EEPROM load data, valid with ee_done |
| ee_done | input | 1 | One-cycle access completion strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 24 | Memory write address |
| mem_wdata | output | 8 | Memory write data |

## Verification
The bench goes after the burst start point in three situations:
- straight after reset, where a design that ignored the "no access yet" rule would start from a stale pointer;
- after a single access, where an off-by-one would reread the last byte;
- after a previous burst, where the run must continue without restarting.

It also sets header offset bit 15 and places a copy across the 15-bit wrap. A design that kept the bit or carried into the base field would write outside the base window.

It checks a zero count, where a broken design would copy 65536 bytes. It checks the combined read-and-write request, where a wrong design would emit a store. It writes to a register while busy, where a leaky design would redirect the access in flight.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD   = 3'd1,
        ST_WR   = 3'd2,
        ST_HDR  = 3'd3,
        ST_COPY = 3'd4
    } nvb_state_e;

    typedef enum logic [2:0] {
        RG_CTRL  = 3'd0,
        RG_ADDR  = 3'd1,
        RG_DATA  = 3'd2,
        RG_BURST = 3'd3,
        RG_BASE  = 3'd4
    } nvb_reg_e;

    localparam int unsigned CTRL_WR_BIT   = 0;
    localparam int unsigned CTRL_RD_BIT   = 1;
    localparam int unsigned CTRL_BUSY_BIT = 2;
    localparam int unsigned LEN_W         = 16;
    localparam int unsigned HDR_BYTES     = 4;

endpackage

// File: rtl/nvb_ctrl_fsm.sv
module nvb_ctrl_fsm
    import nvb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_rd,
    input  logic start_wr,
    input  logic start_burst,
    input  logic ee_done,
    input  logic hdr_last,
    input  logic hdr_len_zero,
    input  logic copy_last,
    output logic busy,
    output logic rd_pend,
    output logic wr_pend,
    output logic burst_act,
    output logic ee_req,
    output logic ee_we,
    output logic rd_fin,
    output logic wr_fin,
    output logic hdr_take,
    output logic copy_take
);

    nvb_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_rd)         st_d = ST_RD;
                else if (start_wr)    st_d = ST_WR;
                else if (start_burst) st_d = ST_HDR;
            end
            ST_RD, ST_WR: begin
                if (ee_done) st_d = ST_IDLE;
            end
            ST_HDR: begin
                if (ee_done && hdr_last)
                    st_d = hdr_len_zero ? ST_IDLE : ST_COPY;
            end
            ST_COPY: begin
                if (ee_done && copy_last) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = (st_q != ST_IDLE);
        rd_pend   = (st_q == ST_RD);
        wr_pend   = (st_q == ST_WR);
        burst_act = (st_q == ST_HDR) || (st_q == ST_COPY);
        ee_req    = busy;
        ee_we     = wr_pend;
        rd_fin    = rd_pend && ee_done;
        wr_fin    = wr_pend && ee_done;
        hdr_take  = (st_q == ST_HDR) && ee_done;
        copy_take = (st_q == ST_COPY) && ee_done;
    end

endmodule

// File: rtl/nvb_datapath.sv
module nvb_datapath
    import nvb_pkg::*;
#(
    parameter int unsigned EE_AW  = 16,
    parameter int unsigned MEM_AW = 24,
    parameter int unsigned OFF_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  nvb_reg_e          reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic              start_burst,
    input  logic              rd_fin,
    input  logic              wr_fin,
    input  logic              hdr_take,
    input  logic              copy_take,
    input  logic [7:0]        ee_rdata,
    output logic [EE_AW-1:0]  addr_q,
    output logic [7:0]        data_q,
    output logic [MEM_AW-OFF_W-1:0] base_q,
    output logic [EE_AW-1:0]  ptr_q,
    output logic              hdr_last,
    output logic              hdr_len_zero,
    output logic              copy_last,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);

    localparam int unsigned BASE_W = MEM_AW - OFF_W;
    localparam int unsigned HI_W   = OFF_W - 8;
    localparam int unsigned IDX_W  = $clog2(HDR_BYTES);

    logic              touched_q;
    logic [IDX_W-1:0]  hidx_q;
    logic [7:0]        off_lo_q;
    logic [7:0]        len_lo_q;
    logic [OFF_W-1:0]  off_q;
    logic [LEN_W-1:0]  rem_q;

    assign hdr_last     = (hidx_q == IDX_W'(HDR_BYTES - 1));
    assign hdr_len_zero = ({ee_rdata, len_lo_q} == '0);
    assign copy_last    = (rem_q == LEN_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            data_q    <= '0;
            base_q    <= '0;
            ptr_q     <= '0;
            touched_q <= 1'b0;
            hidx_q    <= '0;
            off_lo_q  <= '0;
            len_lo_q  <= '0;
            off_q     <= '0;
            rem_q     <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (wr_ok) begin
                case (reg_sel)
                    RG_ADDR: addr_q <= reg_wdata[EE_AW-1:0];
                    RG_DATA: data_q <= reg_wdata[7:0];
                    RG_BASE: base_q <= reg_wdata[BASE_W-1:0];
                    default: ;
                endcase
            end
            if (rd_fin) data_q <= ee_rdata;
            if (rd_fin || wr_fin) begin
                ptr_q     <= addr_q + 1'b1;
                touched_q <= 1'b1;
            end
            if (start_burst) begin
                ptr_q  <= touched_q ? ptr_q : '0;
                hidx_q <= '0;
            end
            if (hdr_take) begin
                ptr_q     <= ptr_q + 1'b1;
                touched_q <= 1'b1;
                hidx_q    <= hidx_q + 1'b1;
                case (hidx_q)
                    2'd0:    off_lo_q <= ee_rdata;
                    2'd1:    off_q    <= {ee_rdata[HI_W-1:0], off_lo_q};
                    2'd2:    len_lo_q <= ee_rdata;
                    default: rem_q    <= {ee_rdata, len_lo_q};
                endcase
            end
            if (copy_take) begin
                ptr_q     <= ptr_q + 1'b1;
                mem_we    <= 1'b1;
                mem_addr  <= {base_q, off_q};
                mem_wdata <= ee_rdata;
                off_q     <= off_q + 1'b1;
                rem_q     <= rem_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/nvb_seq.sv
module nvb_seq
    import nvb_pkg::*;
#(
    parameter int unsigned EE_AW  = 16,
    parameter int unsigned MEM_AW = 24,
    parameter int unsigned OFF_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              ee_req,
    output logic              ee_we,
    output logic [EE_AW-1:0]  ee_addr,
    output logic [7:0]        ee_wdata,
    input  logic [7:0]        ee_rdata,
    input  logic              ee_done,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);

    localparam int unsigned BASE_W = MEM_AW - OFF_W;

    nvb_reg_e reg_sel;
    logic busy, rd_pend, wr_pend, burst_act;
    logic wr_ok, start_rd, start_wr, start_burst;
    logic rd_fin, wr_fin, hdr_take, copy_take;
    logic hdr_last, hdr_len_zero, copy_last;
    logic [EE_AW-1:0]  addr_q, ptr_q;
    logic [7:0]        data_q;
    logic [BASE_W-1:0] base_q;

    assign reg_sel     = nvb_reg_e'(reg_addr);
    assign wr_ok       = reg_we && !busy;
    assign start_rd    = wr_ok && (reg_sel == RG_CTRL) && reg_wdata[CTRL_RD_BIT];
    assign start_wr    = wr_ok && (reg_sel == RG_CTRL) && reg_wdata[CTRL_WR_BIT];
    assign start_burst = wr_ok && (reg_sel == RG_BURST) && reg_wdata[0];

    nvb_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_rd     (start_rd),
        .start_wr     (start_wr),
        .start_burst  (start_burst),
        .ee_done      (ee_done),
        .hdr_last     (hdr_last),
        .hdr_len_zero (hdr_len_zero),
        .copy_last    (copy_last),
        .busy         (busy),
        .rd_pend      (rd_pend),
        .wr_pend      (wr_pend),
        .burst_act    (burst_act),
        .ee_req       (ee_req),
        .ee_we        (ee_we),
        .rd_fin       (rd_fin),
        .wr_fin       (wr_fin),
        .hdr_take     (hdr_take),
        .copy_take    (copy_take)
    );

    nvb_datapath #(
        .EE_AW  (EE_AW),
        .MEM_AW (MEM_AW),
        .OFF_W  (OFF_W)
    ) u_dp (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_ok        (wr_ok),
        .reg_sel      (reg_sel),
        .reg_wdata    (reg_wdata),
        .start_burst  (start_burst),
        .rd_fin       (rd_fin),
        .wr_fin       (wr_fin),
        .hdr_take     (hdr_take),
        .copy_take    (copy_take),
        .ee_rdata     (ee_rdata),
        .addr_q       (addr_q),
        .data_q       (data_q),
        .base_q       (base_q),
        .ptr_q        (ptr_q),
        .hdr_last     (hdr_last),
        .hdr_len_zero (hdr_len_zero),
        .copy_last    (copy_last),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata)
    );

    assign ee_addr  = (rd_pend || wr_pend) ? addr_q : ptr_q;
    assign ee_wdata = data_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            RG_CTRL: begin
                reg_rdata[CTRL_WR_BIT]   = wr_pend;
                reg_rdata[CTRL_RD_BIT]   = rd_pend;
                reg_rdata[CTRL_BUSY_BIT] = busy;
            end
            RG_ADDR:  reg_rdata[EE_AW-1:0]  = addr_q;
            RG_DATA:  reg_rdata[7:0]        = data_q;
            RG_BURST: reg_rdata[0]          = burst_act;
            RG_BASE:  reg_rdata[BASE_W-1:0] = base_q;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/nvb_seq_chk.sv
module nvb_seq_chk #(
    parameter int unsigned EE_AW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ee_req,
    input logic             ee_we,
    input logic [EE_AW-1:0] ee_addr,
    input logic             ee_done,
    input logic [7:0]       ee_rdata,
    input logic             mem_we,
    input logic [7:0]       mem_wdata
);

    // R10: a pending request is held until its done strobe
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && !ee_done) |=> ee_req);

    // R10: address and direction stay fixed while waiting
    p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && !ee_done) |=> ($stable(ee_addr) && $stable(ee_we)));

    // R9: a memory write follows a completed EEPROM access
    p_mem_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(ee_done));

    // R9: the written byte is the one returned by that access
    p_mem_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == $past(ee_rdata)));

    // R9: memory writes are single-cycle pulses when done strobes are isolated
    p_mem_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !ee_done) |=> !mem_we);

endmodule

bind nvb_seq nvb_seq_chk #(.EE_AW(EE_AW)) u_nvb_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ee_req    (ee_req),
    .ee_we     (ee_we),
    .ee_addr   (ee_addr),
    .ee_done   (ee_done),
    .ee_rdata  (ee_rdata),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
);

// File: tb/tb_nvb_seq.sv
`timescale 1ns/1ps
module tb_nvb_seq;

    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ee_req, ee_we;
    logic [15:0] ee_addr;
    logic [7:0]  ee_wdata;
    logic [7:0]  ee_rdata = '0;
    logic        ee_done = 1'b0;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;

    always #2.5 clk = ~clk;

    nvb_seq dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ee_req(ee_req),
        .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
        .ee_rdata(ee_rdata), .ee_done(ee_done), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    logic [7:0]  ee_mem [65536];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 0;

    // reference model state
    int          mode = 0;        // 0 idle, 1 single, 2 burst
    logic [15:0] m_ptr = '0;
    bit          m_touched = 0;
    logic [15:0] sh_addr = '0;
    logic [8:0]  sh_base = '0;
    bit          m_expwe = 0;
    int          m_hidx = 0;
    logic [7:0]  m_hdr [4];
    logic [14:0] m_off = '0;
    int          m_rem = 0;
    logic [31:0] exp_mem [$];
    bit          exp_we_next = 0;
    int          cnt = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic serve();
        logic [7:0] b;
        if (mode == 0) begin
            chk("R10 request while idle", 32'(ee_req), 32'd0);
        end else if (mode == 1) begin
            chk("R1 R2 single address", 32'(ee_addr), 32'(sh_addr));
            chk("R3 single direction", 32'(ee_we), 32'(m_expwe));
            if (ee_we) ee_mem[ee_addr] = ee_wdata;
            ee_rdata = ee_mem[ee_addr];
            m_ptr = sh_addr + 16'd1;
            m_touched = 1;
            mode = 0;
        end else begin
            chk("R6 burst address", 32'(ee_addr), 32'(m_ptr));
            chk("R6 burst is load", 32'(ee_we), 32'd0);
            b = ee_mem[ee_addr];
            ee_rdata = b;
            m_ptr = m_ptr + 16'd1;
            m_touched = 1;
            if (m_hidx < 4) begin
                m_hdr[m_hidx] = b;
                m_hidx++;
                if (m_hidx == 4) begin
                    m_off = {m_hdr[1][6:0], m_hdr[0]};
                    m_rem = int'({m_hdr[3], m_hdr[2]});
                    if (m_rem == 0) mode = 0;
                end
            end else begin
                exp_mem.push_back({sh_base, m_off, b});
                exp_we_next = 1;
                m_off = m_off + 15'd1;
                m_rem--;
                if (m_rem == 0) mode = 0;
            end
        end
        ee_done = 1'b1;
    endtask

    // EEPROM responder and per-cycle comparison of the memory port
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9 mem_we timing", 32'(mem_we), 32'(exp_we_next));
            if (mem_we && exp_mem.size() > 0) begin
                chk("R8 mem_addr", 32'(mem_addr), 32'(exp_mem[0][31:8]));
                chk("R9 mem_wdata", 32'(mem_wdata), 32'(exp_mem[0][7:0]));
                void'(exp_mem.pop_front());
            end
            exp_we_next = 0;
            if (ee_done) begin
                ee_done = 1'b0;
            end else if (ee_req) begin
                cnt++;
                if (cnt >= LAT) begin
                    cnt = 0;
                    serve();
                end
            end
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        #0.5;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        #0.5;
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        #0.5;
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_bit(input logic [2:0] a, input int bitn);
        logic [31:0] d;
        for (int i = 0; i < 2000; i++) begin
            rd_reg(a, d);
            if (!d[bitn]) break;
        end
    endtask

    task automatic start_burst();
        mode = 2;
        m_hidx = 0;
        m_ptr = m_touched ? m_ptr : 16'd0;
        wr_reg(3'd3, 32'd1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R10 watchdog act=running exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 65536; i++) ee_mem[i] = 8'(i * 13 + 5);
        // burst 1 header at 0: offset 0x8005 (bit 15 ignored), count 3
        ee_mem[0] = 8'h05; ee_mem[1] = 8'h80; ee_mem[2] = 8'h03; ee_mem[3] = 8'h00;
        // burst 2 header at 0x301: offset 0xFFFE, count 4 (wraps the 15-bit offset)
        ee_mem[16'h301] = 8'hFE; ee_mem[16'h302] = 8'hFF;
        ee_mem[16'h303] = 8'h04; ee_mem[16'h304] = 8'h00;
        // burst 3 header at 0x309: count 0
        ee_mem[16'h309] = 8'h00; ee_mem[16'h30A] = 8'h00;
        ee_mem[16'h30B] = 8'h00; ee_mem[16'h30C] = 8'h00;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        for (int r = 0; r < 5; r++) begin
            rd_reg(3'(r), d);
            chk("R10 reset register", d, 32'd0);
        end
        chk("R10 reset ee_req", 32'(ee_req), 32'd0);
        chk("R10 reset mem_we", 32'(mem_we), 32'd0);

        // base register
        sh_base = 9'h1A3;
        wr_reg(3'd4, 32'h1A3);
        rd_reg(3'd4, d);
        chk("R8 base readback", d, 32'h1A3);

        // R5 R6 R7 burst straight after reset starts at 0
        start_burst();
        rd_reg(3'd3, d);
        chk("R5 burst bit while running", d, 32'd1);
        rd_reg(3'd0, d);
        chk("R4 busy during burst", 32'(d[2]), 32'd1);
        wait_bit(3'd3, 0);
        rd_reg(3'd3, d);
        chk("R5 burst bit cleared", d, 32'd0);

        // R1 single read with R4 ignored write while busy
        sh_addr = 16'h0100;
        wr_reg(3'd1, 32'h0100);
        mode = 1; m_expwe = 0;
        wr_reg(3'd0, 32'h2);
        rd_reg(3'd0, d);
        chk("R1 read pending bit", 32'(d[1]), 32'd1);
        chk("R4 busy bit", 32'(d[2]), 32'd1);
        wr_reg(3'd1, 32'h1234);
        wait_bit(3'd0, 1);
        rd_reg(3'd2, d);
        chk("R1 read data", d, 32'(ee_mem[16'h0100]));
        rd_reg(3'd1, d);
        chk("R4 address write ignored while busy", d, 32'h0100);
        rd_reg(3'd0, d);
        chk("R4 idle control", d, 32'd0);

        // R2 single write
        sh_addr = 16'h0200;
        wr_reg(3'd1, 32'h0200);
        wr_reg(3'd2, 32'h0000_77A5);
        mode = 1; m_expwe = 1;
        wr_reg(3'd0, 32'h1);
        rd_reg(3'd0, d);
        chk("R2 write pending bit", 32'(d[0]), 32'd1);
        wait_bit(3'd0, 0);
        chk("R2 byte stored", 32'(ee_mem[16'h0200]), 32'hA5);

        // R3 read and write requested together
        sh_addr = 16'h0300;
        wr_reg(3'd1, 32'h0300);
        wr_reg(3'd2, 32'h5A);
        mode = 1; m_expwe = 0;
        wr_reg(3'd0, 32'h3);
        rd_reg(3'd0, d);
        chk("R3 write bit dropped", 32'(d[0]), 32'd0);
        wait_bit(3'd0, 1);
        rd_reg(3'd2, d);
        chk("R3 read performed", d, 32'(8'(16'h0300 * 13 + 5)));
        chk("R3 byte unchanged", 32'(ee_mem[16'h0300]), 32'(8'(16'h0300 * 13 + 5)));

        // R6 R8 burst after a single access, offset wraps
        start_burst();
        wait_bit(3'd3, 0);

        // R7 zero-count burst continues from previous burst
        start_burst();
        wait_bit(3'd3, 0);
        rd_reg(3'd3, d);
        chk("R7 zero count burst ends", d, 32'd0);
        repeat (4) @(negedge clk);
        chk("R9 all expected writes seen", 32'(exp_mem.size()), 32'd0);
        chk("R6 model back to idle", 32'(mode), 32'd0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule